// File: doc/BRIEF.md
# Dual-Mode Program Bank Address Mapper

This block sits between a console CPU's cartridge window (the upper 32 KB of its address space, seen here as a 15-bit offset) and a program ROM. It splits the window into four 8 KB slots and turns each CPU address into a ROM byte address. The ROM address is a per-slot bank number placed above the 13-bit offset inside the slot. One slot region is switchable and the remaining slots are fixed to the highest banks of the ROM. A static mode input picks the scheme. In the narrow scheme, one 8 KB slot is switchable and three slots are fixed. In the wide scheme, a 16 KB pair of slots is switchable and two slots are fixed.

The same window also receives CPU writes. The block decodes these writes into a load of its own program bank register, a nametable mirroring flag, and four write strobes for pattern-table bank registers. Those pattern-table registers are kept outside the block. The strobes carry the CPU data through unchanged. Address translation is combinational. Register loads happen on the clock edge of a qualified write.

Top module: `prg_bank_mapper`

## Requirements
- R1: `prg_addr` equals the slot's bank number concatenated above `cpu_addr[12:0]`. The slot is `cpu_addr[14:13]`.
- R2: With `wide_mode` = 0, slot 0 uses the bank register, and slots 1, 2 and 3 use bank numbers 0xFD, 0xFE and 0xFF.
- R3: With `wide_mode` = 1, slot 0 uses twice the bank register, slot 1 uses twice the register plus one, and slots 2 and 3 use 0xFE and 0xFF.
- R4: Every bank number is ANDed with `PRG_BANKS`−1 before use, where `PRG_BANKS` is the ROM size in 8 KB units and a power of two. Slot 3 therefore always maps to the last bank.
- R5: A write with `cpu_addr[14:12]` = 3'b010 loads `cpu_data` into the bank register at the clock edge. Until that edge, translation uses the old value.
- R6: A write with `cpu_addr[14:12]` equal to 3, 4, 5 or 6 raises `chr_wr_en[0]`, `[1]`, `[2]` or `[3]` respectively, in the same cycle. `chr_wr_data` equals `cpu_data`. At most one strobe is high at a time.
- R7: A write with `cpu_addr[14:12]` = 3'b111 loads `mirror_horiz` from `cpu_data[0]` at the clock edge. A value of 1 means horizontal and 0 means vertical.
- R8: Writes with `cpu_addr[14:12]` of 0 or 1, and any cycle with `cpu_wr` low, change neither the bank register nor the mirroring flag and raise no strobe.
- R9: After reset the bank register is 0 and `mirror_horiz` is 0 (vertical).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 0: one 8 KB switchable slot; 1: one 16 KB switchable region |
| cpu_addr | input | 15 | CPU offset within the cartridge window |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_data | input | DATA_W | CPU write data |
| prg_addr | output | 13+log2(PRG_BANKS) | Translated ROM byte address |
| chr_wr_en | output | 4 | Pattern-table bank register write strobes |
| chr_wr_data | output | DATA_W | Data for the pattern-table bank registers |
| mirror_horiz | output | 1 | Nametable mirroring: 1 horizontal, 0 vertical |

## Verification
A bank register write and an address translation can fall in the same cycle. This happens when the CPU writes to the register's own address range, which lies in slot 1. In the wide scheme that slot depends on the register. The bench holds such a write and reads `prg_addr` twice: once before the clock edge, where it expects the old bank, and once after the edge, where it expects the bank derived from the written data. It also applies a mirroring write and a pattern-table strobe back to back. This confirms that each decode acts only in its own cycle.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int SLOT_OFS_W = 13;

  typedef enum logic [2:0] {
    WR_IGNORE0 = 3'd0,
    WR_IGNORE1 = 3'd1,
    WR_PRG     = 3'd2,
    WR_CHR0    = 3'd3,
    WR_CHR1    = 3'd4,
    WR_CHR2    = 3'd5,
    WR_CHR3    = 3'd6,
    WR_MIRROR  = 3'd7
  } wr_target_e;

  // Raw (unmasked) bank number of a slot.
  function automatic logic [7:0] slot_bank_raw(input logic wide,
                                                input logic [1:0] slot,
                                                input logic [7:0] bank_reg);
    logic [7:0] dbl;
    dbl = {bank_reg[6:0], 1'b0};
    unique case (slot)
      2'd0:    slot_bank_raw = wide ? dbl : bank_reg;
      2'd1:    slot_bank_raw = wide ? (dbl | 8'h01) : 8'hFD;
      2'd2:    slot_bank_raw = 8'hFE;
      default: slot_bank_raw = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/wr_decode.sv
module wr_decode
  import prg_map_pkg::*;
#(
  parameter int N_CHR = 4
) (
  input  logic             cpu_wr,
  input  logic [2:0]       addr_hi,
  output logic             prg_load,
  output logic             mirror_load,
  output logic [N_CHR-1:0] chr_wr_en
);

  wr_target_e target;
  assign target      = wr_target_e'(addr_hi);
  assign prg_load    = cpu_wr && (target == WR_PRG);
  assign mirror_load = cpu_wr && (target == WR_MIRROR);

  for (genvar i = 0; i < N_CHR; i++) begin : g_chr
    assign chr_wr_en[i] = cpu_wr && (addr_hi == 3'(int'(WR_CHR0) + i));
  end

endmodule

// File: rtl/bank_regs.sv
module bank_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prg_load,
  input  logic              mirror_load,
  input  logic [DATA_W-1:0] din,
  output logic [7:0]        prg_reg,
  output logic              mirror_horiz
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_reg      <= '0;
      mirror_horiz <= 1'b0;
    end else begin
      if (prg_load)    prg_reg      <= din[7:0];
      if (mirror_load) mirror_horiz <= din[0];
    end
  end

  assert_prg_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prg_load |=> prg_reg == $past(din[7:0]));
  assert_prg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prg_load |=> $stable(prg_reg));
  assert_mirror_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_load |=> mirror_horiz == $past(din[0]));
  assert_mirror_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mirror_load |=> $stable(mirror_horiz));

endmodule

// File: rtl/slot_xlate.sv
module slot_xlate
  import prg_map_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  localparam int BANK_W   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int OUT_W    = SLOT_OFS_W + BANK_W
) (
  input  logic             wide_mode,
  input  logic [14:0]      cpu_addr,
  input  logic [7:0]       prg_reg,
  output logic [OUT_W-1:0] prg_addr
);

  localparam logic [7:0] BANK_MASK = 8'(PRG_BANKS - 1);

  logic [1:0]        slot;
  logic [7:0]        bank_masked;

  assign slot        = cpu_addr[14:13];
  assign bank_masked = slot_bank_raw(wide_mode, slot, prg_reg) & BANK_MASK;
  assign prg_addr    = {bank_masked[BANK_W-1:0], cpu_addr[SLOT_OFS_W-1:0]};

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int DATA_W    = 8,
  localparam int BANK_W   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
  localparam int OUT_W    = SLOT_OFS_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [14:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [OUT_W-1:0]  prg_addr,
  output logic [3:0]        chr_wr_en,
  output logic [DATA_W-1:0] chr_wr_data,
  output logic              mirror_horiz
);

  logic       prg_load;
  logic       mirror_load;
  logic [7:0] prg_reg;

  wr_decode #(.N_CHR(4)) u_dec (
    .cpu_wr      (cpu_wr),
    .addr_hi     (cpu_addr[14:12]),
    .prg_load    (prg_load),
    .mirror_load (mirror_load),
    .chr_wr_en   (chr_wr_en)
  );

  bank_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .prg_load     (prg_load),
    .mirror_load  (mirror_load),
    .din          (cpu_data),
    .prg_reg      (prg_reg),
    .mirror_horiz (mirror_horiz)
  );

  slot_xlate #(.PRG_BANKS(PRG_BANKS)) u_xlate (
    .wide_mode (wide_mode),
    .cpu_addr  (cpu_addr),
    .prg_reg   (prg_reg),
    .prg_addr  (prg_addr)
  );

  assign chr_wr_data = cpu_data;

  assert_chr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chr_wr_en) && !(|chr_wr_en && (prg_load || mirror_load)));
  assert_chr_needs_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |-> (chr_wr_en == 4'b0) && !prg_load && !mirror_load);
  assert_top_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'b11) |-> (prg_addr[OUT_W-1:SLOT_OFS_W] == BANK_W'(PRG_BANKS - 1)));
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[SLOT_OFS_W-1:0] == cpu_addr[SLOT_OFS_W-1:0]);

endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;

  localparam int PRG_BANKS = 16;
  localparam int OUT_W     = 17;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wide_mode = 1'b0;
  logic [14:0]      cpu_addr = '0;
  logic             cpu_wr = 1'b0;
  logic [7:0]       cpu_data = '0;
  logic [OUT_W-1:0] prg_addr;
  logic [3:0]       chr_wr_en;
  logic [7:0]       chr_wr_data;
  logic             mirror_horiz;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prg_bank_mapper #(.PRG_BANKS(PRG_BANKS), .DATA_W(8)) dut (
    .clk, .rst_n, .wide_mode, .cpu_addr, .cpu_wr, .cpu_data,
    .prg_addr, .chr_wr_en, .chr_wr_data, .mirror_horiz
  );

  // {bank register, wide_mode, cpu_addr, expected prg_addr}
  localparam logic [40:0] VEC [0:10] = '{
    {8'h05, 1'b0, 15'h0123, 17'h0A123},  // R2 slot0
    {8'h05, 1'b0, 15'h2456, 17'h1A456},  // R2 slot1 0xFD masked
    {8'h05, 1'b0, 15'h4FFF, 17'h1CFFF},  // R2 slot2
    {8'h05, 1'b0, 15'h7FFF, 17'h1FFFF},  // R2 slot3
    {8'h13, 1'b0, 15'h0000, 17'h06000},  // R4 register masked
    {8'h03, 1'b1, 15'h0010, 17'h0C010},  // R3 slot0
    {8'h03, 1'b1, 15'h2010, 17'h0E010},  // R3 slot1
    {8'h03, 1'b1, 15'h4000, 17'h1C000},  // R3 slot2
    {8'h03, 1'b1, 15'h6001, 17'h1E001},  // R3 slot3
    {8'h0A, 1'b1, 15'h3ABC, 17'h0BABC},  // R3/R4 doubled+1 masked
    {8'h0A, 1'b1, 15'h0ABC, 17'h08ABC}   // R1/R3 doubled masked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic look(input logic [14:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    look(15'h0000);
    chk("R9 prg reg zero", 32'(prg_addr), 32'h00000);
    chk("R9 mirror vertical", 32'(mirror_horiz), 32'h0);

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      cpu_write(15'h2000, VEC[i][40:33]);
      wide_mode = VEC[i][32];
      look(VEC[i][31:17]);
      chk("R1/R2/R3/R4 table", 32'(prg_addr), 32'(VEC[i][16:0]));
    end

    // R5: write and translation in the same cycle (wide mode, reg 0x0A)
    @(negedge clk);
    cpu_addr = 15'h2000; cpu_data = 8'h09; cpu_wr = 1'b1;
    #1;
    chk("R5 old bank before edge", 32'(prg_addr), 32'h0A000);
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    chk("R5 new bank after edge", 32'(prg_addr), 32'h06000);

    // R6 pattern-table strobes and data
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cpu_addr = 15'((3 + k) << 12) | 15'h0055; cpu_data = 8'(8'hA0 + k); cpu_wr = 1'b1;
      #1;
      chk("R6 strobe", 32'(chr_wr_en), 32'(1 << k));
      chk("R6 data", 32'(chr_wr_data), 32'(8'hA0 + k));
    end
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    chk("R6 no strobe when idle", 32'(chr_wr_en), 32'h0);

    // R7 mirroring
    cpu_write(15'h7000, 8'h01);
    #1;
    chk("R7 horizontal", 32'(mirror_horiz), 32'h1);
    cpu_write(15'h7FFF, 8'hFE);
    #1;
    chk("R7 vertical from bit0", 32'(mirror_horiz), 32'h0);
    cpu_write(15'h7000, 8'h01);

    // R8 ignored writes: reg stays 0x09, mirror stays horizontal
    wide_mode = 1'b0;
    @(negedge clk);
    cpu_addr = 15'h1000; cpu_data = 8'h0E; cpu_wr = 1'b1;
    #1;
    chk("R8 no strobe in ignored range", 32'(chr_wr_en), 32'h0);
    @(negedge clk);
    cpu_addr = 15'h0000; cpu_data = 8'h00; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_addr = 15'h2000; cpu_data = 8'h02; cpu_wr = 1'b0;
    @(negedge clk);
    cpu_addr = 15'h7000; cpu_data = 8'h00; cpu_wr = 1'b0;
    look(15'h0004);
    chk("R8 prg reg unchanged", 32'(prg_addr), 32'h12004);
    chk("R8 mirror unchanged", 32'(mirror_horiz), 32'h1);

    // R9 reset again clears both
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(15'h0004);
    chk("R9 reset clears reg", 32'(prg_addr), 32'h00004);
    chk("R9 reset clears mirror", 32'(mirror_horiz), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule